// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block is the feedback divider of a fractional-N synthesizer loop. It is clocked by the output of an external 32/33 dual-modulus prescaler, so one clock cycle is one prescaler output period. A modulus-control output tells the prescaler, for each of those periods, whether to divide by 33 (high) or by 32 (low). A division lasts N clock cycles. The modulus control is high for the first A of them, plus one more cycle when the fractional accumulator overflowed for that division. This gives 32·N + A + c input periods per division, where c is 0 or 1.

At every division boundary the accumulator adds the numerator F modulo Q, where Q is 5 or 8. Over any Q consecutive divisions exactly F of them are lengthened, so the average ratio is 32·N + A + F/Q. A one-cycle pulse marks the start of each division and goes to the phase comparator.

Settings are written through a strobe into a staging register. A write that breaks a rule is refused and flagged. Staged values are taken up only at the next division boundary.

Top module: `fn_fb_divider`

## Requirements
- R1: After reset, `mod_ctl`, `div_pulse` and `cfg_err` are 0. The first division uses the default settings (N = 34, A = 0, F = 0, Q = 5), so the first `div_pulse` is seen 34 clock cycles after reset is released, with `mod_ctl` low throughout.
- R2: Each division lasts exactly N clock cycles. `div_pulse` is high for only the first cycle of each division.
- R3: Within a division, `mod_ctl` is high for the first A+c cycles and low for the rest, where c is that division's carry (0 or 1). It never goes high again after falling inside a division.
- R4: At each boundary the accumulator adds F. If the sum is at least Q, Q is subtracted and the division that starts is lengthened by one (c = 1). From a zero accumulator with F = 3 and Q = 5, the carries are 0,1,0,1,1.
- R5: `cfg_q8` = 0 selects Q = 5 and `cfg_q8` = 1 selects Q = 8. Over any Q consecutive divisions with fixed settings, the sum of c is exactly F.
- R6: A write with N below 34 (or with A above N) is refused. `cfg_err` is 1 in the cycle after the strobe, and the division length stays at the previously accepted N.
- R7: A write with F not below the selected Q is refused, and `cfg_err` is 1 in the cycle after the strobe.
- R8: Accepted settings take effect only at the next division boundary. A write in the middle of a division leaves that division's length unchanged.
- R9: When a boundary takes up a Q different from the one in use, the accumulator restarts from 0 before F is added.
- R10: An accepted write clears `cfg_err` in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle strobe that stages the settings below |
| cfg_a | input | 5 | Swallow count A |
| cfg_n | input | 10 | Main count N |
| cfg_f | input | 4 | Fractional numerator F |
| cfg_q8 | input | 1 | Fractional modulus select: 0 = 5, 1 = 8 |
| mod_ctl | output | 1 | Prescaler modulus control: 1 = divide by 33, 0 = divide by 32 |
| div_pulse | output | 1 | One-cycle pulse at the start of each division |
| cfg_err | output | 1 | Last write was refused |

## Verification
The hardest case to reach is the accumulator restart on a change of modulus. From the ports it differs from plain continuation only when the accumulator holds a nonzero value at the switch. The stimulus therefore starts from reset, where the accumulator is known to be zero. It then counts divisions with F = 3, Q = 5 until the accumulator is known to hold 3, and switches to Q = 8 with F = 1. A restart puts the only carry of the next eight divisions in the eighth; a stale accumulator would put it in the fifth. A write placed a few cycles into a division covers the boundary-only take-up of new settings.

// File: rtl/fn_div_pkg.sv
package fn_div_pkg;
  localparam int A_W = 5;
  localparam int N_W = 10;
  localparam int F_W = 4;
  localparam int SW_W = A_W + 1;

  typedef struct packed {
    logic           q8;
    logic [F_W-1:0] f;
    logic [A_W-1:0] a;
    logic [N_W-1:0] n;
  } div_cfg_t;
endpackage

// File: rtl/fn_cfg_stage.sv
module fn_cfg_stage
  import fn_div_pkg::*;
#(
  parameter int N_MIN = 34,
  parameter int Q_LO  = 5,
  parameter int Q_HI  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  div_cfg_t       wr_cfg,
  output div_cfg_t       stage,
  output logic           err
);
  localparam int QW = F_W + 1;

  logic [QW-1:0] q_wr;
  logic          n_ok, a_ok, f_ok, ok;

  always_comb begin
    q_wr = wr_cfg.q8 ? QW'(Q_HI) : QW'(Q_LO);
    n_ok = (wr_cfg.n >= N_W'(N_MIN));
    a_ok = (N_W'(wr_cfg.a) <= wr_cfg.n);
    f_ok = ({1'b0, wr_cfg.f} < q_wr);
    ok   = n_ok && a_ok && f_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage.q8 <= 1'b0;
      stage.f  <= '0;
      stage.a  <= '0;
      stage.n  <= N_W'(N_MIN);
      err      <= 1'b0;
    end else if (wr) begin
      err <= !ok;
      if (ok) stage <= wr_cfg;
    end
  end

  p_reject_n_r6: assert property (@(posedge clk) disable iff (rst)
    (wr && !n_ok) |=> err);
  p_reject_f_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && !f_ok) |=> err);
  p_stage_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(stage.n) && $stable(stage.a) && $stable(stage.f) && $stable(stage.q8)));
  p_accept_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && ok) |=> !err);
endmodule

// File: rtl/fn_frac_accum.sv
module fn_frac_accum
  import fn_div_pkg::*;
#(
  parameter int Q_LO = 5,
  parameter int Q_HI = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [F_W-1:0] f_in,
  input  logic           q8_in,
  output logic           carry_nxt
);
  localparam int QW = F_W + 1;

  logic [F_W-1:0] acc;
  logic           q8_cur;
  logic [QW-1:0]  q_new, q_cur, base, sum, acc_nxt;

  always_comb begin
    q_new     = q8_in  ? QW'(Q_HI) : QW'(Q_LO);
    q_cur     = q8_cur ? QW'(Q_HI) : QW'(Q_LO);
    base      = (q8_in != q8_cur) ? '0 : {1'b0, acc};
    sum       = base + {1'b0, f_in};
    carry_nxt = (sum >= q_new);
    acc_nxt   = carry_nxt ? (sum - q_new) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      q8_cur <= 1'b0;
    end else if (step) begin
      acc    <= acc_nxt[F_W-1:0];
      q8_cur <= q8_in;
    end
  end

  p_acc_below_q_r4: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, acc} < q_cur));
  p_acc_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc));
endmodule

// File: rtl/fn_swallow_ctr.sv
module fn_swallow_ctr
  import fn_div_pkg::*;
#(
  parameter int N_MIN = 34
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  input  logic           carry_in,
  output logic           last,
  output logic           mod_ctl,
  output logic           div_pulse
);
  logic [N_W-1:0]  cnt, n_cur, cnt_nxt;
  logic [SW_W-1:0] sw_cur, sw_nxt;

  always_comb begin
    last    = (cnt == n_cur - N_W'(1));
    cnt_nxt = last ? '0 : cnt + N_W'(1);
    sw_nxt  = last ? ({1'b0, a_in} + SW_W'(carry_in)) : sw_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      n_cur     <= N_W'(N_MIN);
      sw_cur    <= '0;
      mod_ctl   <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      mod_ctl   <= (cnt_nxt < N_W'(sw_nxt));
      div_pulse <= last;
      if (last) begin
        n_cur  <= n_in;
        sw_cur <= sw_nxt;
      end
    end
  end

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
  p_mc_no_rerise_r3: assert property (@(posedge clk) disable iff (rst)
    (!mod_ctl && !last) |=> !mod_ctl);
  p_n_boundary_only_r8: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(n_cur));
endmodule

// File: rtl/fn_fb_divider.sv
module fn_fb_divider
  import fn_div_pkg::*;
#(
  parameter int N_MIN = 34,
  parameter int Q_LO  = 5,
  parameter int Q_HI  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [A_W-1:0] cfg_a,
  input  logic [N_W-1:0] cfg_n,
  input  logic [F_W-1:0] cfg_f,
  input  logic           cfg_q8,
  output logic           mod_ctl,
  output logic           div_pulse,
  output logic           cfg_err
);
  div_cfg_t wr_cfg, stage;
  logic     last, carry;

  always_comb begin
    wr_cfg.q8 = cfg_q8;
    wr_cfg.f  = cfg_f;
    wr_cfg.a  = cfg_a;
    wr_cfg.n  = cfg_n;
  end

  fn_cfg_stage #(.N_MIN(N_MIN), .Q_LO(Q_LO), .Q_HI(Q_HI)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wr_cfg(wr_cfg),
    .stage(stage), .err(cfg_err)
  );

  fn_frac_accum #(.Q_LO(Q_LO), .Q_HI(Q_HI)) u_acc (
    .clk(clk), .rst(rst), .step(last), .f_in(stage.f),
    .q8_in(stage.q8), .carry_nxt(carry)
  );

  fn_swallow_ctr #(.N_MIN(N_MIN)) u_ctr (
    .clk(clk), .rst(rst), .a_in(stage.a), .n_in(stage.n),
    .carry_in(carry), .last(last), .mod_ctl(mod_ctl), .div_pulse(div_pulse)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!mod_ctl && !div_pulse && !cfg_err));
endmodule

// File: tb/tb_fn_fb_divider.sv
`timescale 1ns/1ps
module tb_fn_fb_divider;
  logic       clk = 0, rst = 1, cfg_wr = 0, cfg_q8 = 0;
  logic [4:0] cfg_a = 0;
  logic [9:0] cfg_n = 34;
  logic [3:0] cfg_f = 0;
  logic       mod_ctl, div_pulse, cfg_err;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fn_fb_divider dut (.clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_a(cfg_a),
    .cfg_n(cfg_n), .cfg_f(cfg_f), .cfg_q8(cfg_q8), .mod_ctl(mod_ctl),
    .div_pulse(div_pulse), .cfg_err(cfg_err));

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  // fields: {q8, f[3:0], a[4:0], n[9:0]}
  localparam logic [19:0] VEC [0:5] = '{
    {1'b0, 4'd3, 5'd7,  10'd40},
    {1'b1, 4'd5, 5'd31, 10'd34},
    {1'b1, 4'd0, 5'd0,  10'd100},
    {1'b0, 4'd4, 5'd0,  10'd1023},
    {1'b1, 4'd7, 5'd15, 10'd37},
    {1'b0, 4'd1, 5'd31, 10'd35}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int a, input int n, input int f, input bit q8);
    cfg_a = 5'(a); cfg_n = 10'(n); cfg_f = 4'(f); cfg_q8 = q8; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  // starts at a negedge with div_pulse high; ends at the next such negedge
  task automatic measure(output int len, output int hi, output bit contig);
    bit low_seen = 0;
    len = 0; hi = 0; contig = 1;
    do begin
      len++;
      if (mod_ctl) begin hi++; if (low_seen) contig = 0; end
      else low_seen = 1;
      @(negedge clk);
    end while (!div_pulse);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int len, hi, sum;
    bit ct;
    int exp_hi [0:4] = '{2, 3, 2, 3, 3};
    repeat (4) @(negedge clk);
    rst = 0;
    check(!mod_ctl && !div_pulse && !cfg_err, "R1 reset outputs", {mod_ctl, div_pulse, cfg_err}, 0);
    write_cfg(2, 40, 3, 0);
    check(!cfg_err, "R10 valid write", cfg_err, 0);
    wait_pulse();
    check(cyc == 34, "R1 first division length", cyc, 34);
    // divisions 1..5: accumulator from zero, F=3 Q=5
    for (int k = 0; k < 5; k++) begin
      measure(len, hi, ct);
      check(len == 40, "R2 division length", len, 40);
      check(ct, "R3 contiguous mod_ctl", ct, 1);
      check(hi == exp_hi[k], "R4 carry sequence", hi, exp_hi[k]);
    end
    // division 6: write N=60 mid-division, length must stay 40 (R8)
    len = 1;
    repeat (5) begin @(negedge clk); len++; end
    cfg_a = 2; cfg_n = 60; cfg_f = 3; cfg_q8 = 0; cfg_wr = 1;
    @(negedge clk); len++; cfg_wr = 0;
    while (1) begin @(negedge clk); if (div_pulse) break; len++; end
    check(len == 40, "R8 mid-division write", len, 40);
    measure(len, hi, ct);
    check(len == 60, "R8 new N at boundary", len, 60);
    check(hi == 3, "R4 carry div7", hi, 3);
    // division 8: refused writes
    write_cfg(2, 33, 3, 0);
    check(cfg_err, "R6 N below minimum flagged", cfg_err, 1);
    write_cfg(2, 60, 5, 0);
    check(cfg_err, "R7 F not below Q flagged", cfg_err, 1);
    wait_pulse();
    measure(len, hi, ct);
    check(len == 60, "R6 old N kept div9", len, 60);
    measure(len, hi, ct);
    check(len == 60, "R6 old N kept div10", len, 60);
    check(hi == 3, "R4 carry div10", hi, 3);
    // division 11: accumulator holds 3; switch to Q=8, F=1
    write_cfg(0, 34, 1, 1);
    check(!cfg_err, "R10 error cleared", cfg_err, 0);
    wait_pulse();
    for (int k = 0; k < 8; k++) begin
      measure(len, hi, ct);
      check(hi == ((k == 7) ? 1 : 0), "R9 accumulator restart", hi, (k == 7) ? 1 : 0);
    end
    // table of settings
    for (int v = 0; v < 6; v++) begin
      int a, n, f, q;
      bit q8;
      q8 = VEC[v][19]; f = VEC[v][18:15]; a = VEC[v][14:10]; n = VEC[v][9:0];
      q = q8 ? 8 : 5;
      write_cfg(a, n, f, q8);
      check(!cfg_err, "R10 table write accepted", cfg_err, 0);
      wait_pulse();
      sum = 0;
      for (int k = 0; k < q; k++) begin
        measure(len, hi, ct);
        check(len == n, "R2 table length", len, n);
        check(ct && (hi == a || hi == a + 1), "R3 table mod_ctl run", hi, a);
        sum += hi - a;
      end
      check(sum == f, "R5 carries over Q divisions", sum, f);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule